// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller With Row Refresh

This block sits between a simple request port (valid/ready, write flag, flat address, write data) and a dynamic memory whose row and column addresses share one set of address pins. Each flat address is cut into a row field (upper bits) and a column field (lower bits). The row goes out on the shared pins with a row strobe to open that row. The column follows on the same pins with a column strobe to read or write one word.

The controller remembers which row is open. A later access to that row issues only the column strobe. An access to a different row first closes the open one with a precharge strobe, waits out the precharge time, and then opens the new row. A free-running interval timer raises a refresh demand once per interval. An internal counter names the row to refresh, and it moves on by one after every refresh. A refresh opens that row and closes it again without any column access. A refresh demand wins over new requests. If a demand is still unserved when the next interval expires, a sticky error flag is raised.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row field is `req_addr[ADDR_W-1:COL_W]` and the column field is `req_addr[COL_W-1:0]`. The row is driven on `dram_addr` with `dram_ras` high. The column is driven on the same pins with `dram_cas` high. A column strobe never appears unless a row is open.
- R2: A read to the currently open row issues `dram_cas` on the accepting clock edge and no row strobe. `rd_valid` is high in the cycle that follows the second edge after acceptance.
- R3: A read when no row is open issues `dram_ras` on the accepting edge and `dram_cas` T_ACT edges later. `rd_valid` follows T_ACT+2 edges after acceptance.
- R4: A read to a row other than the open one issues `dram_pre` on the accepting edge, `dram_ras` T_PRE edges later and `dram_cas` T_ACT edges after that. `rd_valid` follows T_PRE+T_ACT+2 edges after acceptance. A row strobe is never issued while a row is open, nor fewer than T_PRE cycles after a precharge.
- R5: A write stores `req_wdata` at the addressed word, and a later read of that word returns it on `rd_data`.
- R6: A refresh demand arises every REFI cycles. Each refresh is a row strobe followed by a precharge with no column strobe in between, and it leaves no row open. With no traffic, consecutive refresh row strobes are exactly REFI cycles apart.
- R7: Successive refreshes address rows 0, 1, 2, and so on, wrapping to 0 after row 2^ROW_W-1.
- R8: While a refresh is due, `req_ready` is low and no request is accepted. An open row is precharged before the refresh row strobe, and a request presented meanwhile is served only after the refresh.
- R9: At most one of `dram_ras`, `dram_cas` and `dram_pre` is high in any cycle. `req_ready` is low in every cycle in which any of them is high. Every accepted request drives a strobe in the next cycle.
- R10: `rd_valid` is a one-cycle pulse per read.
- R11: If a refresh is still outstanding when the next interval expires, `refresh_err` goes high and stays high until reset.
- R12: After synchronous reset, all strobes and `rd_valid` are low, `refresh_err` is low, `req_ready` is high and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras | output | 1 | Row open strobe |
| dram_cas | output | 1 | Column access strobe |
| dram_pre | output | 1 | Precharge (row close) strobe |
| dram_we | output | 1 | Write qualifier for the column strobe |
| dram_wdata | output | DATA_W | Data to memory |
| dram_rdata | input | DATA_W | Data from memory, valid the cycle after a read column strobe |
| refresh_err | output | 1 | Sticky missed-refresh flag |

## Verification
Read data is due two edges after acceptance on a row hit, T_ACT+2 edges after acceptance from a closed row, and T_PRE+T_ACT+2 edges after acceptance on a row conflict. The bench takes a snapshot of its own memory model's open-row state at the moment a request is accepted. From that snapshot it derives which of the three latencies applies. It then counts falling edges from acceptance to `rd_valid`, so every output is sampled half a cycle away from the edge that changed it. Refresh spacing is measured in whole cycles between the row strobes of two refreshes with no traffic between them. The missed-deadline flag is checked on a second instance whose interval is shorter than one refresh sequence.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPRE,
    ST_WACT,
    ST_RCLOSE,
    ST_COL,
    ST_RCAP
  } dmc_state_t;
endpackage

// File: rtl/dmc_refresh_timer.sv
module dmc_refresh_timer #(
  parameter int REFI  = 780,
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_err
);
  localparam int CNT_W = (REFI > 1) ? $clog2(REFI) : 1;

  logic [CNT_W-1:0] tmr;
  logic             tick;

  assign tick = (tmr == CNT_W'(REFI - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr         <= '0;
      ref_pending <= 1'b0;
      ref_row     <= '0;
      ref_err     <= 1'b0;
    end else begin
      tmr <= tick ? '0 : tmr + CNT_W'(1);
      if (tick)
        ref_pending <= 1'b1;
      else if (ref_done)
        ref_pending <= 1'b0;
      if (tick && ref_pending && !ref_done)
        ref_err <= 1'b1;
      if (ref_done)
        ref_row <= ref_row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [ROW_W-1:0]       open_row,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic                   hit
);
  assign row = addr[ROW_W+COL_W-1:COL_W];
  assign col = addr[COL_W-1:0];
  assign hit = (row == open_row);
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
  import dmc_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int MUX_W  = 13,
  parameter int DATA_W = 16,
  parameter int T_PRE  = 2,
  parameter int T_ACT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_hit,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [ROW_W-1:0]  open_row,
  input  logic              ref_pending,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_ras,
  output logic              dram_cas,
  output logic              dram_pre,
  output logic              dram_we,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);
  localparam int TMAX = (T_PRE > T_ACT) ? T_PRE : T_ACT;
  localparam int CW   = $clog2(TMAX + 1);

  dmc_state_t        state;
  logic [CW-1:0]     cnt;
  logic              row_open;
  logic              is_ref;
  logic [ROW_W-1:0]  tgt_row;
  logic              op_we;
  logic [COL_W-1:0]  op_col;
  logic [DATA_W-1:0] op_wdata;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_done  = (state == ST_RCLOSE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      row_open   <= 1'b0;
      open_row   <= '0;
      is_ref     <= 1'b0;
      tgt_row    <= '0;
      op_we      <= 1'b0;
      op_col     <= '0;
      op_wdata   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      dram_addr  <= '0;
      dram_ras   <= 1'b0;
      dram_cas   <= 1'b0;
      dram_pre   <= 1'b0;
      dram_we    <= 1'b0;
      dram_wdata <= '0;
    end else begin
      dram_ras <= 1'b0;
      dram_cas <= 1'b0;
      dram_pre <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pending) begin
            is_ref  <= 1'b1;
            tgt_row <= ref_row;
            if (row_open) begin
              dram_pre <= 1'b1;
              row_open <= 1'b0;
              cnt      <= CW'(T_PRE - 1);
              state    <= ST_WPRE;
            end else begin
              dram_ras  <= 1'b1;
              dram_addr <= MUX_W'(ref_row);
              cnt       <= CW'(T_ACT - 1);
              state     <= ST_WACT;
            end
          end else if (req_valid) begin
            is_ref   <= 1'b0;
            tgt_row  <= req_row;
            op_we    <= req_we;
            op_col   <= req_col;
            op_wdata <= req_wdata;
            if (row_open && req_hit) begin
              dram_cas   <= 1'b1;
              dram_addr  <= MUX_W'(req_col);
              dram_we    <= req_we;
              dram_wdata <= req_wdata;
              state      <= ST_COL;
            end else if (row_open) begin
              dram_pre <= 1'b1;
              row_open <= 1'b0;
              cnt      <= CW'(T_PRE - 1);
              state    <= ST_WPRE;
            end else begin
              dram_ras  <= 1'b1;
              dram_addr <= MUX_W'(req_row);
              row_open  <= 1'b1;
              open_row  <= req_row;
              cnt       <= CW'(T_ACT - 1);
              state     <= ST_WACT;
            end
          end
        end
        ST_WPRE: begin
          if (cnt == '0) begin
            dram_ras  <= 1'b1;
            dram_addr <= MUX_W'(tgt_row);
            cnt       <= CW'(T_ACT - 1);
            state     <= ST_WACT;
            if (!is_ref) begin
              row_open <= 1'b1;
              open_row <= tgt_row;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_WACT: begin
          if (cnt == '0) begin
            if (is_ref) begin
              dram_pre <= 1'b1;
              cnt      <= CW'(T_PRE - 1);
              state    <= ST_RCLOSE;
            end else begin
              dram_cas   <= 1'b1;
              dram_addr  <= MUX_W'(op_col);
              dram_we    <= op_we;
              dram_wdata <= op_wdata;
              state      <= ST_COL;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_RCLOSE: begin
          if (cnt == '0)
            state <= ST_IDLE;
          else
            cnt <= cnt - CW'(1);
        end
        ST_COL: begin
          state <= op_we ? ST_IDLE : ST_RCAP;
        end
        ST_RCAP: begin
          rd_data  <= dram_rdata;
          rd_valid <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int REFI   = 780,
  parameter int T_PRE  = 2,
  parameter int T_ACT  = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_ras,
  output logic              dram_cas,
  output logic              dram_pre,
  output logic              dram_we,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              refresh_err
);
  logic             ref_pending;
  logic             ref_done;
  logic [ROW_W-1:0] ref_row;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             req_hit;

  dmc_refresh_timer #(.REFI(REFI), .ROW_W(ROW_W)) u_timer (
    .clk(clk), .rst(rst), .ref_done(ref_done),
    .ref_pending(ref_pending), .ref_row(ref_row), .ref_err(refresh_err)
  );

  dmc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .open_row(open_row),
    .row(req_row), .col(req_col), .hit(req_hit)
  );

  dmc_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W), .DATA_W(DATA_W),
    .T_PRE(T_PRE), .T_ACT(T_ACT)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_row(req_row),
    .req_col(req_col), .req_hit(req_hit), .req_wdata(req_wdata),
    .req_ready(req_ready), .open_row(open_row),
    .ref_pending(ref_pending), .ref_row(ref_row), .ref_done(ref_done),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas),
    .dram_pre(dram_pre), .dram_we(dram_we), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int T_PRE = 2
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras,
  input logic dram_cas,
  input logic dram_pre,
  input logic refresh_err
);
  localparam int SW = $clog2(T_PRE + 1) + 1;

  logic          open_q;
  logic [SW-1:0] since_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      since_pre <= SW'(T_PRE);
    end else begin
      if (dram_ras) open_q <= 1'b1;
      else if (dram_pre) open_q <= 1'b0;
      if (dram_pre) since_pre <= SW'(1);
      else if (since_pre < SW'(T_PRE)) since_pre <= since_pre + SW'(1);
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dram_ras, dram_cas, dram_pre}));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (dram_ras || dram_cas || dram_pre) |-> !req_ready);

  a_r9_accept_cmd: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (dram_ras || dram_cas || dram_pre));

  a_r4_no_double_open: assert property (@(posedge clk) disable iff (rst)
    dram_ras |-> !open_q);

  a_r4_pre_window: assert property (@(posedge clk) disable iff (rst)
    dram_ras |-> (since_pre >= SW'(T_PRE)));

  a_r1_col_needs_row: assert property (@(posedge clk) disable iff (rst)
    dram_cas |-> open_q);

  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    refresh_err |=> refresh_err);
endmodule

bind dram_mux_ctrl dmc_checker #(.T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .dram_ras(dram_ras), .dram_cas(dram_cas),
  .dram_pre(dram_pre), .refresh_err(refresh_err)
);

// File: tb/dram_mux_ctrl_tb.sv
module dram_mux_ctrl_tb;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 3;
  localparam int DATA_W = 8;
  localparam int REFI   = 64;
  localparam int T_PRE  = 3;
  localparam int T_ACT  = 2;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              rst_s = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [MUX_W-1:0]  dram_addr;
  logic              dram_ras, dram_cas, dram_pre, dram_we;
  logic [DATA_W-1:0] dram_wdata;
  logic [DATA_W-1:0] dram_rdata = '0;
  logic              refresh_err;

  logic              s_ready, s_rdv, s_ras, s_cas, s_pre, s_we, s_err;
  logic [DATA_W-1:0] s_rdata, s_wdata;
  logic [MUX_W-1:0]  s_addr;

  dram_mux_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REFI(REFI),
                  .T_PRE(T_PRE), .T_ACT(T_ACT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_pre(dram_pre),
    .dram_we(dram_we), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .refresh_err(refresh_err)
  );

  dram_mux_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REFI(4),
                  .T_PRE(T_PRE), .T_ACT(T_ACT)) u_dut_short (
    .clk(clk), .rst(rst_s), .req_valid(1'b0), .req_ready(s_ready),
    .req_we(1'b0), .req_addr('0), .req_wdata('0),
    .rd_valid(s_rdv), .rd_data(s_rdata), .dram_addr(s_addr),
    .dram_ras(s_ras), .dram_cas(s_cas), .dram_pre(s_pre),
    .dram_we(s_we), .dram_wdata(s_wdata), .dram_rdata('0),
    .refresh_err(s_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory model, sampled at the falling edge
  logic [DATA_W-1:0] m_mem [0:(1<<ADDR_W)-1];
  logic              m_open = 1'b0;
  logic [ROW_W-1:0]  m_row = '0;
  logic              m_no_cas = 1'b0;
  int                m_pre_cyc = -1000;
  int                m_act_cyc = 0;
  int                m_act_row = 0;
  int                m_cas_col = 0;
  int                m_cas_cyc = 0;
  int                ref_cnt = 0;
  int                ref_act_cyc = 0;
  int                exp_ref_row = 0;

  initial for (int i = 0; i < (1 << ADDR_W); i++) m_mem[i] = '0;

  always @(negedge clk) begin
    if (!rst && (dram_ras || dram_cas || dram_pre)) begin
      check(($countones({dram_ras, dram_cas, dram_pre}) == 1) && !req_ready, "R9",
            int'({req_ready, dram_ras, dram_cas, dram_pre}), 0);
      if (dram_ras) begin
        check(!m_open, "R4 open while open", int'(m_open), 0);
        check((cyc - m_pre_cyc) >= T_PRE, "R4 precharge window", cyc - m_pre_cyc, T_PRE);
        m_open    = 1'b1;
        m_row     = dram_addr[ROW_W-1:0];
        m_no_cas  = 1'b1;
        m_act_cyc = cyc;
        m_act_row = int'(dram_addr[ROW_W-1:0]);
      end
      if (dram_cas) begin
        check(m_open, "R1 column without row", int'(m_open), 1);
        m_no_cas  = 1'b0;
        m_cas_col = int'(dram_addr[COL_W-1:0]);
        m_cas_cyc = cyc;
        if (dram_we) m_mem[{m_row, dram_addr[COL_W-1:0]}] = dram_wdata;
        else dram_rdata = m_mem[{m_row, dram_addr[COL_W-1:0]}];
      end
      if (dram_pre) begin
        if (m_open && m_no_cas) begin
          check(int'(m_row) == exp_ref_row, "R7 refresh row", int'(m_row), exp_ref_row);
          exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
          ref_act_cyc = m_act_cyc;
          ref_cnt++;
        end
        m_open    = 1'b0;
        m_pre_cyc = cyc;
      end
    end
  end

  // caller is at a falling edge
  task automatic access(input bit we, input int row, input int col, input int wd,
                        output int q);
    int lat;
    bit hit, was_open;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = ADDR_W'(row * (1 << COL_W) + col);
    req_wdata = DATA_W'(wd);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    was_open = m_open;
    hit      = m_open && (int'(m_row) == row);
    @(negedge clk);
    req_valid = 1'b0;
    q = 0;
    if (!we) begin
      lat = 0;
      while (!rd_valid && lat < 60) begin @(negedge clk); lat++; end
      q = int'(rd_data);
      if (hit) check(lat == 2, "R2 hit latency", lat, 2);
      else if (was_open) check(lat == T_PRE + T_ACT + 2, "R4 conflict latency", lat, T_PRE + T_ACT + 2);
      else check(lat == T_ACT + 2, "R3 closed latency", lat, T_ACT + 2);
      check(m_cas_col == col, "R1 column on pins", m_cas_col, col);
      if (!hit) check(m_act_row == row, "R1 row on pins", m_act_row, row);
      @(negedge clk);
      check(rd_valid == 1'b0, "R10 pulse", int'(rd_valid), 0);
    end
  endtask

  task automatic wait_refresh();
    int c0 = ref_cnt;
    while (ref_cnt == c0) @(negedge clk);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R12 ready", int'(req_ready), 1);
    check({dram_ras, dram_cas, dram_pre, rd_valid} == 4'b0, "R12 strobes",
          int'({dram_ras, dram_cas, dram_pre, rd_valid}), 0);
    check(refresh_err == 1'b0, "R12 err", int'(refresh_err), 0);
  endtask

  task automatic t_basic();
    int q;
    access(1'b1, 2, 1, 8'hA5, q);
    access(1'b0, 2, 1, 0, q);
    check(q == 8'hA5, "R5 readback", q, 8'hA5);
    access(1'b1, 2, 5, 8'h3C, q);
    access(1'b0, 2, 5, 0, q);
    check(q == 8'h3C, "R5 readback hit", q, 8'h3C);
    access(1'b0, 2, 1, 0, q);
    check(q == 8'hA5, "R2 second hit", q, 8'hA5);
  endtask

  task automatic t_conflict();
    int q;
    access(1'b1, 9, 3, 8'h77, q);
    access(1'b0, 2, 1, 0, q);
    check(q == 8'hA5, "R4 data after conflict", q, 8'hA5);
    access(1'b0, 9, 3, 0, q);
    check(q == 8'h77, "R4 data row 9", q, 8'h77);
  endtask

  task automatic t_refresh_idle();
    int t1;
    wait_refresh();
    wait_refresh();
    t1 = ref_act_cyc;
    wait_refresh();
    check(ref_act_cyc - t1 == REFI, "R6 spacing", ref_act_cyc - t1, REFI);
    check(!m_open, "R6 row left closed", int'(m_open), 0);
  endtask

  task automatic t_priority();
    int q, t, c0;
    wait_refresh();
    t = ref_act_cyc;
    access(1'b0, 6, 2, 0, q);
    while (cyc != t + REFI - 1) @(negedge clk);
    check(req_ready == 1'b0, "R8 ready low while due", int'(req_ready), 0);
    c0 = ref_cnt;
    access(1'b0, 11, 4, 0, q);
    check(ref_cnt == c0 + 1, "R8 refresh served", ref_cnt, c0 + 1);
    check(ref_act_cyc < m_cas_cyc, "R8 refresh first", ref_act_cyc, m_cas_cyc);
    access(1'b0, 2, 5, 0, q);
    check(q == 8'h3C, "R5 data kept", q, 8'h3C);
  endtask

  task automatic t_wrap();
    while (ref_cnt < (1 << ROW_W) + 2) @(negedge clk);
    check(exp_ref_row == ref_cnt % (1 << ROW_W), "R7 wrap", exp_ref_row, ref_cnt % (1 << ROW_W));
  endtask

  task automatic t_err();
    check(s_err == 1'b1, "R11 set", int'(s_err), 1);
    repeat (30) @(negedge clk);
    check(s_err == 1'b1, "R11 sticky", int'(s_err), 1);
    rst_s = 1'b1;
    @(negedge clk);
    rst_s = 1'b0;
    check(s_err == 1'b0, "R11 cleared by reset", int'(s_err), 0);
    check(refresh_err == 1'b0, "R11 main no miss", int'(refresh_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst   = 1'b0;
    rst_s = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_conflict();
    t_refresh_idle();
    t_priority();
    t_wrap();
    t_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule